// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This block keeps the status register of a serial nonvolatile memory and rules on every write. The register holds a busy flag, a write-enable latch, two block-protect bits that fence off part of the array, and a lock-enable bit that lets an external guard pin freeze the status register. A command engine in front of the block decodes the serial stream. It sends the block one-cycle requests: set or clear the latch, stage a new status value, commit the staged value when chip-select rises, and ask whether a write starting at a given address may run. An external write timer supplies the busy level.

The block answers with one-cycle go or deny pulses and with a registered byte that the engine shifts out on a status read. When a grant is given, the engine starts the timed write cycle. The nonvolatile bits are modeled with ordinary flip-flops that clear on reset. The array size is a parameter, and the protected ranges scale with it.

Top module: `sr_guard`

## Requirements
- R1: After reset, stat_byte reads 8'h00 and sr_go, wr_go and wr_deny are low.
- R2: stat_byte is registered, so it shows the state one clock later. When busy_in is low it reads {lock_en, 3'b000, bp[1:0], wel, 1'b0}, with lock_en in bit 7, bp in bits 3:2, the latch in bit 1 and busy in bit 0. One clock after busy_in is high it reads 8'hFF.
- R3: set_wel sets the write-enable latch and clr_wel clears it, whatever the level of hw_guard_n. When both arrive in the same cycle, the latch is cleared.
- R4: The latch clears on the clock edge where busy_in is first seen low after being high.
- R5: sr_commit produces an sr_go pulse and loads sr_new_lock_en and sr_new_bp only if all of these hold: a value was staged by sr_stage, the latch is 1 and busy_in is low. The other status bits keep their meaning.
- R6: The hardware lock is active when hw_guard_n is 0 and lock_en is 1. While it is active at commit, the status write is refused and the latch is kept. When lock_en is 0, hw_guard_n has no effect.
- R7: If the hardware lock becomes active at any time between stage and commit, the staged value is dropped, even if the pin is high again at commit.
- R8: Block-protect code bp = 00 protects no address. Code 01 protects addresses at or above 3/4 of the array (17'h18000 by default). Code 10 protects the upper half (17'h10000 and up). Code 11 protects every address.
- R9: A wr_req while the latch is 0 produces wr_deny and no wr_go.
- R10: A wr_req with the latch set and a start address in a protected range produces wr_deny and clears the latch. The other status bits keep their values.
- R11: While busy_in is high, wr_req and sr_commit produce no pulse, and sr_stage stages nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_guard_n | input | 1 | Guard pin level; 0 requests the hardware lock |
| busy_in | input | 1 | Timed write cycle in progress |
| set_wel | input | 1 | Set write-enable latch |
| clr_wel | input | 1 | Clear write-enable latch |
| sr_stage | input | 1 | Stage a new status value |
| sr_new_lock_en | input | 1 | Staged lock-enable bit |
| sr_new_bp | input | 2 | Staged block-protect code |
| sr_commit | input | 1 | Chip-select rose after a status write |
| wr_req | input | 1 | Array write request at chip-select rise |
| wr_addr | input | ADDR_W | Start address of the array write |
| sr_go | output | 1 | Status write accepted; start the write cycle |
| wr_go | output | 1 | Array write accepted; start the write cycle |
| wr_deny | output | 1 | Array write refused |
| stat_byte | output | 8 | Byte to shift out on a status read |

## Verification
A latch stuck in either state shows up on the next status read as a wrong bit 1. Within one request it also shows up as a wr_go where a wr_deny belongs, or the reverse. A wrong protect decode grants or refuses a write at the range edges, one address below or at each boundary, on the clock after the request. A lock that is evaluated only at commit, or a staged value that survives a busy cycle, shows up as a wrong sr_go and as a stale bit 7 or bits 3:2 two clocks later.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int SR_W        = 8;
  localparam int POS_LOCK_EN = 7;
  localparam int POS_BP_HI   = 3;
  localparam int POS_BP_LO   = 2;
  localparam int POS_WEL     = 1;
  localparam int POS_BUSY    = 0;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_code_e;

  typedef struct packed {
    logic     lock_en;
    bp_code_e bp;
  } nv_bits_t;
endpackage

// File: rtl/sg_wel.sv
module sg_wel (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic set_req,
  input  logic clr_req,
  input  logic kill_req,
  output logic wel
);
  logic busy_q;
  logic busy_end;

  assign busy_end = busy_q & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wel    <= 1'b0;
    end else begin
      busy_q <= busy;
      if (busy_end || kill_req || (clr_req && !busy))
        wel <= 1'b0;
      else if (set_req && !busy)
        wel <= 1'b1;
    end
  end

  // R3: a clear request outside busy always leaves the latch at 0
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !busy) |=> !wel);
  // R10: a protected-range rejection drops the latch
  assert_kill_drops_R10: assert property (@(posedge clk) disable iff (rst)
    kill_req |=> !wel);
  // R11: the latch cannot rise while a cycle runs
  assert_no_rise_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !wel) |=> !wel);
endmodule

// File: rtl/sg_nvreg.sv
module sg_nvreg
  import sg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     busy,
  input  logic     lock,
  input  logic     wel,
  input  logic     stage,
  input  logic     stage_lock_en,
  input  logic [1:0] stage_bp,
  input  logic     commit,
  output nv_bits_t nv,
  output logic     go
);
  logic     pend_q;
  nv_bits_t pend_val;
  logic     accept;

  assign accept = commit && pend_q && wel && !lock && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      pend_val <= '0;
      nv       <= '0;
      go       <= 1'b0;
    end else begin
      go <= accept;
      if (accept)
        nv <= pend_val;
      if (lock || commit || busy)
        pend_q <= 1'b0;
      else if (stage) begin
        pend_q   <= 1'b1;
        pend_val <= '{lock_en: stage_lock_en, bp: bp_code_e'(stage_bp)};
      end
    end
  end

  // R5: the nonvolatile bits move only together with a grant
  assert_nv_only_on_go_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(nv) |-> go);
  // R6: a grant implies latch set and no lock in the commit cycle
  assert_go_needs_wel_R6: assert property (@(posedge clk) disable iff (rst)
    go |-> $past(wel && !lock && !busy));
  // R7: an active lock always discards the staged value
  assert_lock_cancels_R7: assert property (@(posedge clk) disable iff (rst)
    lock |=> !pend_q);
endmodule

// File: rtl/sg_wrgate.sv
module sg_wrgate
  import sg_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              wel,
  input  bp_code_e          bp,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              kill,
  output logic              go,
  output logic              deny
);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);

  logic in_fence;
  logic live;

  always_comb begin
    unique case (bp)
      BP_NONE:    in_fence = 1'b0;
      BP_QUARTER: in_fence = (addr >= QTR_BASE);
      BP_HALF:    in_fence = (addr >= HALF_BASE);
      default:    in_fence = 1'b1;
    endcase
  end

  assign live = req && !busy;
  assign kill = live && wel && in_fence;

  always_ff @(posedge clk) begin
    if (rst) begin
      go   <= 1'b0;
      deny <= 1'b0;
    end else begin
      go   <= live && wel && !in_fence;
      deny <= live && (!wel || in_fence);
    end
  end

  // R9: grant only with the latch set
  assert_go_needs_wel_R9: assert property (@(posedge clk) disable iff (rst)
    go |-> $past(wel));
  // R8: grant and refusal are exclusive
  assert_go_xor_deny_R8: assert property (@(posedge clk) disable iff (rst)
    !(go && deny));
  // R11: no answer of any kind to a request made while busy
  assert_quiet_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (go || deny) |-> $past(req && !busy));
endmodule

// File: rtl/sg_statview.sv
module sg_statview
  import sg_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  nv_bits_t        nv,
  input  logic            wel,
  output logic [SR_W-1:0] stat
);
  logic [SR_W-1:0] idle_view;

  always_comb begin
    idle_view              = '0;
    idle_view[POS_LOCK_EN] = nv.lock_en;
    idle_view[POS_BP_HI]   = nv.bp[1];
    idle_view[POS_BP_LO]   = nv.bp[0];
    idle_view[POS_WEL]     = wel;
    idle_view[POS_BUSY]    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      stat <= '0;
    else
      stat <= busy ? '1 : idle_view;
  end

  // R2: busy forces an all-ones view on the next clock
  assert_busy_ones_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> (stat == '1));
  // R2: idle view keeps the unused bits at zero
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (stat[6:4] == 3'b000 && stat[POS_BUSY] == 1'b0));
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_guard_n,
  input  logic              busy_in,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              sr_stage,
  input  logic              sr_new_lock_en,
  input  logic [1:0]        sr_new_bp,
  input  logic              sr_commit,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              sr_go,
  output logic              wr_go,
  output logic              wr_deny,
  output logic [7:0]        stat_byte
);
  nv_bits_t nv;
  logic     wel;
  logic     lock;
  logic     kill;

  assign lock = nv.lock_en && !hw_guard_n;

  sg_wel u_wel (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy_in),
    .set_req  (set_wel),
    .clr_req  (clr_wel),
    .kill_req (kill),
    .wel      (wel)
  );

  sg_nvreg u_nvreg (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy_in),
    .lock          (lock),
    .wel           (wel),
    .stage         (sr_stage),
    .stage_lock_en (sr_new_lock_en),
    .stage_bp      (sr_new_bp),
    .commit        (sr_commit),
    .nv            (nv),
    .go            (sr_go)
  );

  sg_wrgate #(.ADDR_W(ADDR_W)) u_wrgate (
    .clk  (clk),
    .rst  (rst),
    .busy (busy_in),
    .wel  (wel),
    .bp   (nv.bp),
    .req  (wr_req),
    .addr (wr_addr),
    .kill (kill),
    .go   (wr_go),
    .deny (wr_deny)
  );

  sg_statview u_statview (
    .clk  (clk),
    .rst  (rst),
    .busy (busy_in),
    .nv   (nv),
    .wel  (wel),
    .stat (stat_byte)
  );

  // R1: only one grant kind at a time
  assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
    !(sr_go && wr_go));
endmodule

// File: tb/sr_guard_bench.sv
module sr_guard_bench;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_guard_n = 1'b1, busy_in = 1'b0, set_wel = 1'b0, clr_wel = 1'b0;
  logic sr_stage = 1'b0, sr_new_lock_en = 1'b0, sr_commit = 1'b0, wr_req = 1'b0;
  logic [1:0] sr_new_bp = 2'b00;
  logic [AW-1:0] wr_addr = '0;
  logic sr_go, wr_go, wr_deny;
  logic [7:0] stat_byte;

  int total = 0;
  int bad = 0;
  bit m_wel = 0, m_lock_en = 0;
  bit [1:0] m_bp = 0;

  always #5 clk = ~clk;

  sr_guard #(.ADDR_W(AW)) u_sr_guard (
    .clk(clk), .rst(rst), .hw_guard_n(hw_guard_n), .busy_in(busy_in),
    .set_wel(set_wel), .clr_wel(clr_wel), .sr_stage(sr_stage),
    .sr_new_lock_en(sr_new_lock_en), .sr_new_bp(sr_new_bp), .sr_commit(sr_commit),
    .wr_req(wr_req), .wr_addr(wr_addr), .sr_go(sr_go), .wr_go(wr_go),
    .wr_deny(wr_deny), .stat_byte(stat_byte)
  );

  function automatic bit fenced(bit [1:0] bp, logic [AW-1:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a >= 17'h18000;
      2'b10: return a >= 17'h10000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat();
    return {m_lock_en, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_stat(string tag);
    tick(); tick();
    chk(stat_byte == exp_stat(), tag, stat_byte, exp_stat());
  endtask

  task automatic do_set();
    set_wel = 1; tick(); set_wel = 0; m_wel = 1;
  endtask

  task automatic do_clr(bit pin);
    hw_guard_n = pin; clr_wel = 1; tick(); clr_wel = 0; hw_guard_n = 1; m_wel = 0;
  endtask

  task automatic busy_cycle(int n, bit probe);
    busy_in = 1; tick(); tick();
    chk(stat_byte == 8'hFF, "R2 busy view", stat_byte, 8'hFF);
    if (probe) begin
      wr_req = 1; wr_addr = '0; tick(); wr_req = 0;
      chk(!wr_go && !wr_deny, "R11 wr during busy", {wr_go, wr_deny}, 0);
      sr_stage = 1; sr_new_lock_en = 1; sr_new_bp = 2'b11; tick(); sr_stage = 0;
      sr_commit = 1; tick(); sr_commit = 0;
      chk(!sr_go, "R11 commit during busy", sr_go, 0);
      hw_guard_n = 0; tick(); hw_guard_n = 1;
    end
    repeat (n) tick();
    busy_in = 0; m_wel = 0;
    check_stat("R4 latch clears at busy end");
  endtask

  task automatic do_sr(bit le, bit [1:0] bp, bit pd, bit pc, string tag);
    bit expgo;
    sr_stage = 1; sr_new_lock_en = le; sr_new_bp = bp; hw_guard_n = 1; tick();
    sr_stage = 0; hw_guard_n = pd; tick();
    sr_commit = 1; hw_guard_n = pc; tick();
    sr_commit = 0; hw_guard_n = 1;
    expgo = m_wel && !(m_lock_en && !pd) && !(m_lock_en && !pc);
    chk(sr_go == expgo, tag, sr_go, expgo);
    if (expgo) begin
      m_lock_en = le; m_bp = bp;
      busy_cycle(3, 0);
    end
  endtask

  task automatic do_wr(logic [AW-1:0] a, string tag);
    bit eg, ed;
    wr_req = 1; wr_addr = a; tick(); wr_req = 0;
    eg = m_wel && !fenced(m_bp, a);
    ed = !eg;
    chk(wr_go == eg && wr_deny == ed, tag, {wr_go, wr_deny}, {eg, ed});
    if (m_wel && fenced(m_bp, a)) m_wel = 0;
    if (eg) busy_cycle(2, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    repeat (3) tick();
    chk(stat_byte == 8'h00 && !sr_go && !wr_go && !wr_deny, "R1 reset", stat_byte, 0);
    rst = 0;
    tick();
    chk(stat_byte == 8'h00 && !sr_go && !wr_go && !wr_deny, "R1 after reset", stat_byte, 0);

    do_wr(17'h00010, "R9 write with latch clear");
    do_set(); check_stat("R3 set latch");
    do_clr(1); check_stat("R3 clear latch");
    set_wel = 1; clr_wel = 1; tick(); set_wel = 0; clr_wel = 0; m_wel = 0;
    check_stat("R3 clear wins");

    do_set(); do_sr(0, 2'b01, 1, 1, "R5 status write accepted");
    check_stat("R5 new protect bits");
    do_set(); do_wr(17'h17FFF, "R8 below quarter fence");
    do_set(); do_wr(17'h18000, "R10 quarter fence deny");
    check_stat("R10 latch dropped, bits kept");

    do_set(); do_sr(1, 2'b10, 1, 1, "R5 lock enable set");
    check_stat("R2 layout 88");
    do_set(); do_wr(17'h0FFFF, "R8 below half fence");
    do_set(); do_wr(17'h10000, "R8 half fence deny");
    do_set(); do_sr(0, 2'b00, 1, 0, "R6 locked at commit");
    check_stat("R6 latch kept, bits kept");
    do_sr(0, 2'b00, 0, 1, "R7 lock between stage and commit");
    check_stat("R7 bits kept");
    do_clr(0); check_stat("R3 clear with pin low");
    do_wr(17'h00000, "R9 latch clear deny");

    do_set(); do_sr(0, 2'b11, 1, 1, "R5 lock enable cleared");
    do_set(); do_wr(17'h00000, "R8 all protected");
    do_set(); do_sr(0, 2'b00, 0, 0, "R6 pin ignored when lock_en 0");
    check_stat("R6 bits after unlocked write");

    do_set(); do_sr(1, 2'b01, 1, 1, "R5 reload");
    busy_in = 1; tick();
    sr_stage = 1; sr_new_lock_en = 0; sr_new_bp = 2'b11; tick(); sr_stage = 0;
    busy_in = 0; m_wel = 0; tick();
    do_set();
    sr_commit = 1; tick(); sr_commit = 0;
    chk(!sr_go, "R11 stage during busy dropped", sr_go, 0);
    check_stat("R11 bits unchanged");
    do_set(); do_wr(17'h00100, "R8 low address go");
    do_set(); wr_req = 1; wr_addr = '0; tick(); wr_req = 0; tick();
    busy_cycle(2, 1);

    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: do_set();
        1: do_clr(1'($urandom));
        2: do_sr(1'($urandom), 2'($urandom), ($urandom % 4) != 0,
                 ($urandom % 4) != 0, "R6 random status write");
        3: do_wr(AW'($urandom), "R8 random write");
        4: begin do_set(); do_wr(AW'($urandom), "R10 random write"); end
        default: check_stat("R2 random view");
      endcase
    end
    check_stat("R2 final view");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule